// File: doc/BRIEF.md
# Four-Bit Carry Lookahead Adder Slice

This block adds two 4-bit operands and a carry-in in pure combinational logic. It does not pass a carry from one bit position to the next. Each bit first forms a generate term (both operand bits set) and a propagate term (either operand bit set). Every internal carry is then written as a flat sum of products over those terms and the slice carry-in. As a result, every carry sees the same logic depth, whatever its bit position.

Besides the sum and the carry-out, the slice exports a group generate and a group propagate. A higher lookahead level can then compute the carries between slices without waiting on this slice's carry-out. The block has no clock and no reset, and it holds no state.

Top module: `cla4_lookahead_slice`

## Requirements
- R1: `sum_o` equals the low four bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit 4 of the 5-bit result of `a_i + b_i + cin_i`.
- R3: `grp_gen_o` is 1 exactly when `a_i + b_i` (without the carry-in) is at least 16, so it does not depend on `cin_i`.
- R4: `grp_prop_o` is 1 exactly when every bit position has at least one operand bit set, that is when `(a_i | b_i) == 4'b1111`.
- R5: `cout_o` always equals `grp_gen_o | (grp_prop_o & cin_i)`.
- R6: `a_i = 4'b0001`, `b_i = 4'b1011` and `cin_i = 0` give `sum_o = 4'b1100`, `cout_o = 0`, `grp_gen_o = 0` and `grp_prop_o = 0`.
- R7: The sum stays correct at positions where both operand bits are 1. Each sum bit is the XOR of the two operand bits and the incoming carry, not the propagate term XOR the carry.
- R8: The outputs are combinational. When all inputs are zero, all outputs are zero. A change on the inputs shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| cout_o | output | 1 | Carry out of bit 3 |
| grp_gen_o | output | 1 | Group generate: the slice produces a carry on its own |
| grp_prop_o | output | 1 | Group propagate: the slice passes its carry-in through |

## Verification
The bench sweeps all 512 combinations of the operands and the carry-in. It aims at the positions where both operand bits are set. A design that formed each sum bit from the OR-based propagate term would produce a wrong sum there, even though its carries were right. It also aims at the all-propagate cases such as 1111 + 0000. In those cases a group generate that wrongly included the carry-in term would assert, and a carry-out that dropped the final product term would lose the incoming carry. The worked example 0001 + 1011 is checked on its own, because its carry passes through bit 1 and stops at bit 2. A slip in any single product term would show up there.

// File: rtl/cla4_pkg.sv
package cla4_pkg;

    localparam int SLICE_W = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;

    // Per-bit carry behaviour: produce a carry, or pass one through.
    function automatic gp_pair_t bit_gp(input logic x, input logic y);
        gp_pair_t r;
        r.gen  = x & y;
        r.prop = x | y;
        return r;
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp
    import cla4_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0]     a_i,
    input  logic [WIDTH-1:0]     b_i,
    output gp_pair_t [WIDTH-1:0] gp_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gp_o[i] = bit_gp(a_i[i], b_i[i]);
    end

endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net
    import cla4_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  gp_pair_t [WIDTH-1:0] gp_i,
    input  logic                 cin_i,
    output logic [WIDTH:0]       carry_o
);

    // Each carry is an independent flat sum of products over g, p and cin.
    always_comb begin
        logic acc;
        logic term;
        logic chain;
        carry_o[0] = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                term = gp_i[j].gen;
                for (int k = j + 1; k <= i; k++) begin
                    term = term & gp_i[k].prop;
                end
                acc = acc | term;
            end
            chain = cin_i;
            for (int k = 0; k <= i; k++) begin
                chain = chain & gp_i[k].prop;
            end
            carry_o[i+1] = acc | chain;
        end
    end

endmodule

// File: rtl/cla_group_terms.sv
module cla_group_terms
    import cla4_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  gp_pair_t [WIDTH-1:0] gp_i,
    output logic                 grp_gen_o,
    output logic                 grp_prop_o
);

    always_comb begin
        logic term;
        grp_gen_o  = 1'b0;
        grp_prop_o = 1'b1;
        for (int j = 0; j < WIDTH; j++) begin
            term = gp_i[j].gen;
            for (int k = j + 1; k < WIDTH; k++) begin
                term = term & gp_i[k].prop;
            end
            grp_gen_o  = grp_gen_o | term;
            grp_prop_o = grp_prop_o & gp_i[j].prop;
        end
    end

endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage
    import cla4_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] sum_o
);

    // Propagate is an OR, so the half-sum is taken from the operands.
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry_i[i];
    end

endmodule

// File: rtl/cla4_lookahead_slice.sv
module cla4_lookahead_slice
    import cla4_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             grp_gen_o,
    output logic             grp_prop_o
);

    gp_pair_t [WIDTH-1:0] gp_w;
    logic [WIDTH:0]       carry_w;

    cla_bit_gp #(.WIDTH(WIDTH)) u_gp (
        .a_i (a_i),
        .b_i (b_i),
        .gp_o(gp_w)
    );

    cla_carry_net #(.WIDTH(WIDTH)) u_carry (
        .gp_i   (gp_w),
        .cin_i  (cin_i),
        .carry_o(carry_w)
    );

    cla_group_terms #(.WIDTH(WIDTH)) u_group (
        .gp_i      (gp_w),
        .grp_gen_o (grp_gen_o),
        .grp_prop_o(grp_prop_o)
    );

    cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .a_i    (a_i),
        .b_i    (b_i),
        .carry_i(carry_w[WIDTH-1:0]),
        .sum_o  (sum_o)
    );

    assign cout_o = carry_w[WIDTH];

endmodule

// File: rtl/cla4_lookahead_slice_chk.sv
module cla4_lookahead_slice_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic             grp_gen_o,
    input logic             grp_prop_o,
    input logic [WIDTH:0]   carry_w
);

    logic [WIDTH:0] full_w;
    logic [WIDTH:0] nocin_w;
    logic           known_w;

    assign full_w  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    assign nocin_w = {1'b0, a_i} + {1'b0, b_i};
    assign known_w = !$isunknown({a_i, b_i, cin_i});

    always_comb begin
        if (known_w) begin
            // R1 and R7: sum bits from operands and the carry network
            p_sum_bits_r1: assert (sum_o == full_w[WIDTH-1:0])
                else $error("sum mismatch");
            p_sum_xor_r7: assert (sum_o == (a_i ^ b_i ^ carry_w[WIDTH-1:0]))
                else $error("sum not formed from operand xor");
            p_cout_r2: assert (cout_o == full_w[WIDTH])
                else $error("carry-out mismatch");
            p_group_gen_r3: assert (grp_gen_o == nocin_w[WIDTH])
                else $error("group generate mismatch");
            p_group_prop_r4: assert (grp_prop_o == (&(a_i | b_i)))
                else $error("group propagate mismatch");
            p_cout_combine_r5: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i)))
                else $error("carry-out not G + P.cin");
        end
    end

endmodule

bind cla4_lookahead_slice cla4_lookahead_slice_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .cin_i     (cin_i),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o),
    .carry_w   (carry_w)
);

// File: tb/cla4_lookahead_slice_bench.sv
`timescale 1ns/1ps
module cla4_lookahead_slice_bench;

    logic       clk = 1'b0;
    logic [3:0] a, b;
    logic       cin;
    logic [3:0] sum;
    logic       cout, ggen, gprop;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    cla4_lookahead_slice u_cla4_lookahead_slice (
        .a_i       (a),
        .b_i       (b),
        .cin_i     (cin),
        .sum_o     (sum),
        .cout_o    (cout),
        .grp_gen_o (ggen),
        .grp_prop_o(gprop)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s a=%b b=%b cin=%b actual=%0d expected=%0d",
                     req, what, a, b, cin, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ta, input logic [3:0] tb, input logic tc);
        @(posedge clk);
        a = ta; b = tb; cin = tc;
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        @(negedge clk);
        // R8: zero inputs give zero outputs
        check({sum, cout, ggen, gprop} == 7'd0, "R8", "zero state",
              int'({sum, cout, ggen, gprop}), 0);

        // R6: worked example
        drive(4'b0001, 4'b1011, 1'b0);
        check(sum == 4'b1100, "R6", "sum", sum, 12);
        check(cout == 1'b0, "R6", "cout", cout, 0);
        check(ggen == 1'b0, "R6", "group gen", ggen, 0);
        check(gprop == 1'b0, "R6", "group prop", gprop, 0);

        // R8: output follows input with no clock edge in between
        a = 4'b1111; b = 4'b0000; cin = 1'b1;
        #1;
        check(sum == 4'b0000 && cout == 1'b1, "R8", "no-clock update",
              int'({cout, sum}), 16);

        // Exhaustive sweep: R1, R2, R3, R4, R5, R7
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    int tot, raw;
                    bit eg, ep;
                    drive(4'(ia), 4'(ib), 1'(ic));
                    tot = ia + ib + ic;
                    raw = ia + ib;
                    eg  = (raw >= 16);
                    ep  = ((ia | ib) == 15);
                    if ((ia & ib) != 0)
                        check(int'(sum) == (tot % 16), "R7", "sum with both bits set", sum, tot % 16);
                    else
                        check(int'(sum) == (tot % 16), "R1", "sum", sum, tot % 16);
                    check(int'(cout) == (tot / 16), "R2", "cout", cout, tot / 16);
                    check(ggen == eg, "R3", "group gen", ggen, int'(eg));
                    check(gprop == ep, "R4", "group prop", gprop, int'(ep));
                    check(cout == (ggen | (gprop & cin)), "R5", "cout vs G/P",
                          cout, int'(ggen | (gprop & cin)));
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule